// File: doc/BRIEF.md
# Destination Address Receive Filter

This block sits on the receive side of an Ethernet port. It looks at the 48-bit destination address of each arriving frame and decides whether the frame is kept or thrown away. A frame is kept when its address equals any exact-match table entry whose enable bit is set. A frame is also kept when range mode is on and the address falls inside an inclusive unsigned window. If the window is set from all zeros to all ones, every frame is kept, which gives promiscuous reception.

Software configures the block through a small synchronous register port. The port holds the control word, the window limits, the exact-match table and two read-only statistics counters. One counter counts kept frames and the other counts dropped frames. Each counter runs only while its own enable bit is set, and it stops at its maximum value. The decision for a frame appears one clock after the frame's address strobe.

Register word map: 0 control, 1 window low limit, 2 window high limit, 3 kept counter, 4 dropped counter, and 8 plus the entry index for table entries. Control bits: bit 0 is range mode, bit 1 is the kept-counter enable, bit 2 is the dropped-counter enable, and bit 4 plus the entry index is that entry's enable.

Top module: `dmf_filter`

## Requirements
- R1: After reset, table entry 0 holds the broadcast address (all ones) with its enable bit set, so the control word reads 0x10. Both counters read 0 and dec_valid is low. Broadcast frames are kept with no further setup.
- R2: For each cycle with hdr_valid high, dec_valid is high in the next cycle. In that same cycle, dec_accept is high exactly when the frame is kept. dec_valid is low in every other cycle.
- R3: A frame is kept when hdr_dmac equals an entry whose enable bit is set. An entry whose enable bit is clear never matches.
- R4: Table entry i is written and read back at register word 8+i, in bits 47:0 of the data.
- R5: The enable bit of entry i is control bit 4+i.
- R6: When control bit 0 is set, a frame is kept if low <= hdr_dmac <= high, as an unsigned 48-bit compare, with both limits included.
- R7: When control bit 0 is clear, the window limits have no effect on the decision.
- R8: With the window set from 0 to all ones and range mode on, every address is kept.
- R9: The kept counter (word 3) adds one per kept frame only while control bit 1 is set. The dropped counter (word 4) adds one per dropped frame only while control bit 2 is set.
- R10: Each counter holds at its maximum value instead of wrapping. The counters are 32 bits wide by default.
- R11: A register write in the same cycle as a frame strobe takes effect only for later frames. The frame in that cycle is judged on the settings from before the write.
- R12: Writes to the counter words are ignored.
- R13: A read returns data on reg_rdata in the cycle after reg_rd is high. Unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hdr_valid | input | 1 | Destination address strobe, one cycle per frame |
| hdr_dmac | input | 48 | Destination address of the frame |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after reg_rd |

## Verification
Two things can happen in the same cycle: a configuration write and a frame decision. The bench drives a table-entry write, and separately a control write that sets or clears an entry enable, on the very clock edge where the matching address is strobed. It then checks that the decision for that frame follows the old settings and that the next frame follows the new ones. A write to a counter word is also made next to a counting frame. The bench judges it by reading back the counter value.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int REG_AW = 5;
  localparam int DATA_W = 64;

  localparam logic [REG_AW-1:0] A_CTRL   = 5'd0;
  localparam logic [REG_AW-1:0] A_RLO    = 5'd1;
  localparam logic [REG_AW-1:0] A_RHI    = 5'd2;
  localparam logic [REG_AW-1:0] A_PASS   = 5'd3;
  localparam logic [REG_AW-1:0] A_DISC   = 5'd4;
  localparam int                ENT_BASE   = 8;
  localparam int                ENT_STRIDE = 1;

  localparam int CB_RANGE   = 0;
  localparam int CB_PASS    = 1;
  localparam int CB_DISC    = 2;
  localparam int CB_ENT_LSB = 4;
endpackage

// File: rtl/dmf_sat_counter.sv
module dmf_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  always_comb begin
    step  = en && inc && (cnt_q != MAXV);
    cnt_d = cnt_q;
    if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9: counts by exactly one when enabled and not at the limit
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inc && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R9: no count without enable and event
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && inc) |=> $stable(cnt_q));
  // R10: saturated value is kept
  p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV) |=> (cnt_q == MAXV));
endmodule

// File: rtl/dmf_match.sv
module dmf_match #(
  parameter int NUM_ENT = 4,
  parameter int ADDR_W  = 48
) (
  input  logic [ADDR_W-1:0]              dmac,
  input  logic [NUM_ENT-1:0][ADDR_W-1:0] ent_addr,
  input  logic [NUM_ENT-1:0]             ent_en,
  input  logic                           range_en,
  input  logic [ADDR_W-1:0]              rng_lo,
  input  logic [ADDR_W-1:0]              rng_hi,
  output logic                           hit
);
  logic [NUM_ENT-1:0] ent_hit;
  logic               rng_hit;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    assign ent_hit[i] = ent_en[i] && (ent_addr[i] == dmac);
  end

  assign rng_hit = range_en && (dmac >= rng_lo) && (dmac <= rng_hi);
  assign hit     = (|ent_hit) || rng_hit;
endmodule

// File: rtl/dmf_cfg_regs.sv
module dmf_cfg_regs import dmf_pkg::*; #(
  parameter int NUM_ENT = 4,
  parameter int ADDR_W  = 48,
  parameter int CNT_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [REG_AW-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  input  logic [CNT_W-1:0]               pass_cnt,
  input  logic [CNT_W-1:0]               disc_cnt,
  output logic [DATA_W-1:0]              rd_data,
  output logic [NUM_ENT-1:0][ADDR_W-1:0] ent_addr,
  output logic [NUM_ENT-1:0]             ent_en,
  output logic                           range_en,
  output logic                           pass_en,
  output logic                           disc_en,
  output logic [ADDR_W-1:0]              rng_lo,
  output logic [ADDR_W-1:0]              rng_hi
);
  localparam int CTRL_W = CB_ENT_LSB + NUM_ENT;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << CB_ENT_LSB;

  logic [CTRL_W-1:0]              ctrl_q, ctrl_d;
  logic [NUM_ENT-1:0][ADDR_W-1:0] ents_q, ents_d;
  logic [ADDR_W-1:0]              lo_q, lo_d, hi_q, hi_d;
  logic [DATA_W-1:0]              rdata_q, rdata_d, rsel;
  logic                           unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:ADDR_W];

  // write next-state
  always_comb begin
    ctrl_d = ctrl_q;
    ents_d = ents_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl_d = reg_wdata[CTRL_W-1:0];
      if (reg_addr == A_RLO)  lo_d   = reg_wdata[ADDR_W-1:0];
      if (reg_addr == A_RHI)  hi_d   = reg_wdata[ADDR_W-1:0];
      for (int i = 0; i < NUM_ENT; i++) begin
        if (int'(reg_addr) == ENT_BASE + i * ENT_STRIDE)
          ents_d[i] = reg_wdata[ADDR_W-1:0];
      end
    end
  end

  // read select
  always_comb begin
    rsel = '0;
    case (reg_addr)
      A_CTRL: rsel = DATA_W'(ctrl_q);
      A_RLO:  rsel = DATA_W'(lo_q);
      A_RHI:  rsel = DATA_W'(hi_q);
      A_PASS: rsel = DATA_W'(pass_cnt);
      A_DISC: rsel = DATA_W'(disc_cnt);
      default: rsel = '0;
    endcase
    for (int i = 0; i < NUM_ENT; i++) begin
      if (int'(reg_addr) == ENT_BASE + i * ENT_STRIDE)
        rsel = DATA_W'(ents_q[i]);
    end
    rdata_d = reg_rd ? rsel : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      lo_q    <= '0;
      hi_q    <= '0;
      rdata_q <= '0;
      for (int i = 0; i < NUM_ENT; i++)
        ents_q[i] <= (i == 0) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};
    end else begin
      ctrl_q  <= ctrl_d;
      ents_q  <= ents_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      rdata_q <= rdata_d;
    end
  end

  assign rd_data  = rdata_q;
  assign ent_addr = ents_q;
  assign ent_en   = ctrl_q[CB_ENT_LSB +: NUM_ENT];
  assign range_en = ctrl_q[CB_RANGE];
  assign pass_en  = ctrl_q[CB_PASS];
  assign disc_en  = ctrl_q[CB_DISC];
  assign rng_lo   = lo_q;
  assign rng_hi   = hi_q;

  // R4: a write to entry word 8 lands in entry 0
  p_ent_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_addr) == ENT_BASE) |=> (ent_addr[0] == $past(reg_wdata[ADDR_W-1:0])));
  // R13: read data is captured only on a read strobe
  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(rd_data));
endmodule

// File: rtl/dmf_filter.sv
module dmf_filter import dmf_pkg::*; #(
  parameter int NUM_ENT = 4,
  parameter int ADDR_W  = 48,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [ADDR_W-1:0] hdr_dmac,
  output logic              dec_valid,
  output logic              dec_accept,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [1:0]                     rst_sync_q;
  logic                           rst_i_n;
  logic [NUM_ENT-1:0][ADDR_W-1:0] ent_addr;
  logic [NUM_ENT-1:0]             ent_en;
  logic                           range_en, pass_en, disc_en;
  logic [ADDR_W-1:0]              rng_lo, rng_hi;
  logic [CNT_W-1:0]               pass_cnt, disc_cnt;
  logic                           hit;
  logic                           dv_q, dv_d, da_q, da_d;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  dmf_cfg_regs #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pass_cnt(pass_cnt), .disc_cnt(disc_cnt), .rd_data(reg_rdata),
    .ent_addr(ent_addr), .ent_en(ent_en), .range_en(range_en),
    .pass_en(pass_en), .disc_en(disc_en), .rng_lo(rng_lo), .rng_hi(rng_hi)
  );

  dmf_match #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_match (
    .dmac(hdr_dmac), .ent_addr(ent_addr), .ent_en(ent_en),
    .range_en(range_en), .rng_lo(rng_lo), .rng_hi(rng_hi), .hit(hit)
  );

  dmf_sat_counter #(.W(CNT_W)) u_pass_cnt (
    .clk(clk), .rst_n(rst_i_n), .en(pass_en), .inc(hdr_valid && hit), .cnt(pass_cnt)
  );

  dmf_sat_counter #(.W(CNT_W)) u_disc_cnt (
    .clk(clk), .rst_n(rst_i_n), .en(disc_en), .inc(hdr_valid && !hit), .cnt(disc_cnt)
  );

  always_comb begin
    dv_d = hdr_valid;
    da_d = hdr_valid && hit;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dv_q <= 1'b0;
      da_q <= 1'b0;
    end else begin
      dv_q <= dv_d;
      da_q <= da_d;
    end
  end

  assign dec_valid  = dv_q;
  assign dec_accept = da_q;

  // R2: one decision per strobe, one cycle later
  p_dec_lat_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    hdr_valid |=> dec_valid);
  p_no_dec_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !hdr_valid |=> !dec_valid);
  // R2: no keep indication without a decision
  p_acc_qual_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    dec_accept |-> dec_valid);
  // R12: counter words are not writable
  p_cnt_ro_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_wr && reg_addr == A_PASS && !hdr_valid) |=> $stable(pass_cnt));
endmodule

// File: tb/dmf_filter_bench.sv
module dmf_filter_bench;
  import dmf_pkg::*;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [47:0] hdr_dmac = '0;
  logic        dec_valid, dec_accept;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  logic [63:0] ctrl = 64'h10;

  always #10 clk = ~clk;

  dmf_filter #(.NUM_ENT(4), .ADDR_W(48), .CNT_W(CW)) u_dmf_filter (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dmac(hdr_dmac),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [63:0] exp, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic frame(input logic [47:0] a, input bit exp, input string req);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_dmac = a;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk(dec_valid && dec_accept == exp, req, {62'd0, dec_valid, dec_accept}, {62'd0, 1'b1, exp});
    @(negedge clk);
    chk(!dec_valid, req, {63'd0, dec_valid}, 64'd0);
  endtask

  task automatic t_reset;
    chk(!dec_valid, "R1", {63'd0, dec_valid}, 0);
    rd_chk(5'd0, 64'h10, "R1");
    rd_chk(5'd8, 64'hFFFF_FFFF_FFFF, "R1");
    rd_chk(5'd3, 0, "R1");
    rd_chk(5'd4, 0, "R1");
    frame(48'hFFFF_FFFF_FFFF, 1'b1, "R1");
    frame(48'h0000_1234_5678, 1'b0, "R2");
  endtask

  task automatic t_exact;
    wr(5'd10, 64'h0000_0A0B_0C0D_0E0F);
    rd_chk(5'd10, 64'h0000_0A0B_0C0D_0E0F, "R4");
    frame(48'h0A0B_0C0D_0E0F, 1'b0, "R3");
    ctrl = ctrl | 64'h40; wr(5'd0, ctrl);
    frame(48'h0A0B_0C0D_0E0F, 1'b1, "R5");
    wr(5'd11, 64'h0000_1111_2222_3333);
    frame(48'h1111_2222_3333, 1'b0, "R3");
    ctrl = ctrl | 64'h80; wr(5'd0, ctrl);
    frame(48'h1111_2222_3333, 1'b1, "R5");
    frame(48'h1111_2222_3334, 1'b0, "R3");
  endtask

  task automatic t_range;
    wr(5'd1, 64'd100);
    wr(5'd2, 64'd200);
    frame(48'd150, 1'b0, "R7");
    ctrl = ctrl | 64'h1; wr(5'd0, ctrl);
    frame(48'd99,  1'b0, "R6");
    frame(48'd100, 1'b1, "R6");
    frame(48'd200, 1'b1, "R6");
    frame(48'd201, 1'b0, "R6");
    wr(5'd1, 64'd0);
    wr(5'd2, 64'h0000_FFFF_FFFF_FFFF);
    frame(48'h8000_0000_0001, 1'b1, "R8");
    frame(48'd0, 1'b1, "R8");
    ctrl = ctrl & ~64'h1; wr(5'd0, ctrl);
    frame(48'h8000_0000_0001, 1'b0, "R7");
  endtask

  task automatic t_count;
    rd_chk(5'd3, 0, "R9");
    rd_chk(5'd4, 0, "R9");
    ctrl = ctrl | 64'h6; wr(5'd0, ctrl);
    for (int i = 0; i < 3; i++) frame(48'hFFFF_FFFF_FFFF, 1'b1, "R9");
    for (int i = 0; i < 2; i++) frame(48'h0000_0000_0123, 1'b0, "R9");
    rd_chk(5'd3, 64'd3, "R9");
    rd_chk(5'd4, 64'd2, "R9");
    ctrl = ctrl & ~64'h2; wr(5'd0, ctrl);
    frame(48'hFFFF_FFFF_FFFF, 1'b1, "R9");
    rd_chk(5'd3, 64'd3, "R9");
    wr(5'd3, 64'd9);
    rd_chk(5'd3, 64'd3, "R12");
    for (int i = 0; i < 20; i++) frame(48'h0000_0000_0123, 1'b0, "R10");
    rd_chk(5'd4, 64'd15, "R10");
  endtask

  task automatic t_collide;
    logic [47:0] c;
    c = 48'h0055_6677_8899;
    @(negedge clk);
    hdr_valid = 1'b1; hdr_dmac = c; reg_wr = 1'b1; reg_addr = 5'd9; reg_wdata = {16'd0, c};
    @(negedge clk);
    hdr_valid = 1'b0; reg_wr = 1'b0;
    chk(dec_valid && !dec_accept, "R11", {62'd0, dec_valid, dec_accept}, 64'h2);
    ctrl = ctrl | 64'h20;
    @(negedge clk);
    hdr_valid = 1'b1; reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = ctrl;
    @(negedge clk);
    hdr_valid = 1'b0; reg_wr = 1'b0;
    chk(dec_valid && !dec_accept, "R11", {62'd0, dec_valid, dec_accept}, 64'h2);
    frame(c, 1'b1, "R11");
    ctrl = ctrl & ~64'h20;
    @(negedge clk);
    hdr_valid = 1'b1; reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = ctrl;
    @(negedge clk);
    hdr_valid = 1'b0; reg_wr = 1'b0;
    chk(dec_valid && dec_accept, "R11", {62'd0, dec_valid, dec_accept}, 64'h3);
    frame(c, 1'b0, "R11");
    rd_chk(5'd0, ctrl, "R13");
    rd_chk(5'd20, 64'd0, "R13");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_exact();
    t_range();
    t_count();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule